// File: doc/BRIEF.md
# Privilege-Aware Trap Interrupt Prioritizer

This block keeps one pending flag for each of seven interrupt sources and, when the core raises a take request, picks the single trap to take in that cycle. Which source wins, and whether any source can win, depends on several inputs: the privilege mode (hypervisor or not), the global interrupt-enable bit, the current trap level, the trap-level-zero enable, the software-interrupt register and the processor interrupt level.

Sources are posted one per cycle by index. The decision is combinational. The valid pulse, trap code, software-interrupt level and clear mask appear in the same cycle as the take request. The pending flag of the taken source drops at the next clock edge. The clear mask names the single bit of the software-interrupt register that belongs to the delivered level, so that the logic owning that register can clear it.

Top module: `trap_irq_arbiter`

## Requirements
- R1: After reset no flag is pending: `irq_pending`, `trap_vld` and `post_err` are all 0.
- R2: Source indices (also used as `trap_code`) are: 0 trap-level-zero, 1 hypervisor tick match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 resumable error, 6 soft interrupt. A post with `post_vld` high sets the flag of `post_idx`. `irq_pending` is high while any flag is set. Posting an already pending source has no further effect, so a single take clears it.
- R3: A post with `post_idx` = 7 changes no flag and sets `post_err`. `post_err` stays set until reset.
- R4: With `hpriv` high, nothing is taken unless `ie` is high. When `ie` is high, tick match (1) wins over interrupt vector (2), and every other source stays pending.
- R5: With `hpriv` low, trap-level-zero (0) has the highest priority. It is eligible only when `tlz_en` is high and `tl` is 0.
- R6: With `hpriv` low, tick match (1) is next in priority and is taken even when `ie` is low.
- R7: With `hpriv` low and `ie` high, the sources after tick match rank in this order: CPU mondo (3), device mondo (4), soft interrupt (6), resumable error (5).
- R8: The soft level is the index of the highest set bit among bits 15..1 of `softint`. Bit 0 is ignored, and a level of 0 means none. When a soft interrupt is pending, its level is below 6 and the interrupt vector is pending, the interrupt vector (2) is taken in the soft interrupt's place.
- R9: A soft interrupt is delivered only if its level is strictly greater than `pil`. On delivery, `trap_lvl` carries the level and `lvl_clr_mask` has only that level's bit set. For every other take both outputs are 0.
- R10: On delivery, the soft interrupt flag is cleared only if no bit of `softint` among bits 15..1 is set other than the delivered level's bit.
- R11: A take request with no eligible source gives no `trap_vld` and changes no flag.
- R12: If a post and a take of the same source fall in one cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_vld | input | 1 | Post strobe |
| post_idx | input | 3 | Index of the source to post |
| take_req | input | 1 | Core asks for a trap this cycle |
| hpriv | input | 1 | Hypervisor-privileged mode |
| ie | input | 1 | Global interrupt enable |
| tlz_en | input | 1 | Trap-level-zero enable |
| tl | input | TL_W (3) | Current trap level |
| softint | input | SI_W (16) | Software-interrupt register |
| pil | input | LVL_W (4) | Processor interrupt level |
| irq_pending | output | 1 | Any flag pending |
| trap_vld | output | 1 | A source was taken this cycle |
| trap_code | output | 3 | Index of the taken source |
| trap_lvl | output | LVL_W (4) | Delivered soft level, else 0 |
| lvl_clr_mask | output | SI_W (16) | Bit of the delivered level, else 0 |
| post_err | output | 1 | Sticky out-of-range post flag |

## Verification
The hardest case to reach is the one where the soft interrupt and the interrupt vector are both pending. Here the outcome hinges at once on the soft level, on `pil` and on which other `softint` bits remain. The bench reaches it by resetting before each table row and posting a chosen set of sources. It then presents one take with a crafted `softint` value, using single-bit, multi-bit and bit-0-only patterns, and checks `irq_pending` one edge later to see whether the flag survived.

// File: rtl/trap_irq_arbiter.sv
module trap_irq_arbiter #(
  parameter int SI_W  = 16,
  parameter int TL_W  = 3,
  parameter int LVL_W = $clog2(SI_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_vld,
  input  logic [2:0]       post_idx,
  input  logic             take_req,
  input  logic             hpriv,
  input  logic             ie,
  input  logic             tlz_en,
  input  logic [TL_W-1:0]  tl,
  input  logic [SI_W-1:0]  softint,
  input  logic [LVL_W-1:0] pil,
  output logic             irq_pending,
  output logic             trap_vld,
  output logic [2:0]       trap_code,
  output logic [LVL_W-1:0] trap_lvl,
  output logic [SI_W-1:0]  lvl_clr_mask,
  output logic             post_err
);
  localparam int SRC_N = 7;
  localparam logic [2:0] S_TLZ = 3'd0, S_TICK = 3'd1, S_VEC = 3'd2, S_CPU = 3'd3,
                         S_DEV = 3'd4, S_RES = 3'd5, S_SOFT = 3'd6;

  logic [SRC_N-1:0] pend, pend_nxt;
  logic [LVL_W-1:0] lvl;
  logic [SI_W-1:0]  lvl_bit, rest;
  logic             hit, keep_soft, post_ok;
  logic [2:0]       sel;

  always_comb begin
    lvl = '0;
    for (int i = 1; i < SI_W; i++)
      if (softint[i]) lvl = LVL_W'(i);
  end

  assign lvl_bit = {{(SI_W-1){1'b0}}, 1'b1} << lvl;
  assign rest    = softint & ~lvl_bit & ~{{(SI_W-1){1'b0}}, 1'b1};

  always_comb begin
    hit = 1'b0;
    sel = S_TLZ;
    if (hpriv) begin
      if (ie) begin
        if (pend[S_TICK])     begin hit = 1'b1; sel = S_TICK; end
        else if (pend[S_VEC]) begin hit = 1'b1; sel = S_VEC;  end
      end
    end else if (pend[S_TLZ] && tlz_en && tl == '0) begin
      hit = 1'b1; sel = S_TLZ;
    end else if (pend[S_TICK]) begin
      hit = 1'b1; sel = S_TICK;
    end else if (ie) begin
      if (pend[S_CPU])                                          begin hit = 1'b1; sel = S_CPU;  end
      else if (pend[S_DEV])                                     begin hit = 1'b1; sel = S_DEV;  end
      else if (pend[S_SOFT] && lvl < LVL_W'(6) && pend[S_VEC]) begin hit = 1'b1; sel = S_VEC;  end
      else if (pend[S_SOFT] && lvl > pil)                       begin hit = 1'b1; sel = S_SOFT; end
      else if (pend[S_RES])                                     begin hit = 1'b1; sel = S_RES;  end
    end
  end

  assign trap_vld     = take_req && hit;
  assign trap_code    = trap_vld ? sel : 3'd0;
  assign trap_lvl     = (trap_vld && sel == S_SOFT) ? lvl : '0;
  assign lvl_clr_mask = (trap_vld && sel == S_SOFT) ? lvl_bit : '0;
  assign keep_soft    = sel == S_SOFT && |rest;
  assign post_ok      = post_vld && int'(post_idx) < SRC_N;
  assign irq_pending  = |pend;

  always_comb begin
    pend_nxt = pend;
    for (int i = 0; i < SRC_N; i++) begin
      if (trap_vld && sel == 3'(i) && !keep_soft) pend_nxt[i] = 1'b0;
      if (post_ok && post_idx == 3'(i))           pend_nxt[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      post_err <= 1'b0;
    end else begin
      pend <= pend_nxt;
      if (post_vld && !post_ok) post_err <= 1'b1;
    end
  end
endmodule

module trap_irq_arbiter_chk #(
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             post_vld,
  input logic [2:0]       post_idx,
  input logic             hpriv,
  input logic             ie,
  input logic             tlz_en,
  input logic             tl_zero,
  input logic [LVL_W-1:0] pil,
  input logic             trap_vld,
  input logic [2:0]       trap_code,
  input logic [LVL_W-1:0] trap_lvl,
  input logic             irq_pending,
  input logic             post_err
);
  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_err |=> post_err);
  // R12
  post_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vld && post_idx != 3'd7) |=> irq_pending);
  // R4
  hpriv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hpriv && !ie) |-> !trap_vld);
  // R4
  hpriv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && hpriv) |-> (trap_code == 3'd1 || trap_code == 3'd2));
  // R5
  tlz_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && trap_code == 3'd0) |-> (!hpriv && tlz_en && tl_zero));
  // R9
  soft_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && trap_code == 3'd6) |-> trap_lvl > pil);
  // R2
  take_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld |-> irq_pending);
endmodule

bind trap_irq_arbiter trap_irq_arbiter_chk #(.LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_idx(post_idx),
  .hpriv(hpriv), .ie(ie), .tlz_en(tlz_en), .tl_zero(tl == '0), .pil(pil),
  .trap_vld(trap_vld), .trap_code(trap_code), .trap_lvl(trap_lvl),
  .irq_pending(irq_pending), .post_err(post_err));

// File: tb/trap_irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module trap_irq_arbiter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic post_vld = 1'b0, take_req = 1'b0, hpriv = 1'b0, ie = 1'b0, tlz_en = 1'b0;
  logic [2:0] post_idx = '0, tl = '0;
  logic [15:0] softint = '0;
  logic [3:0] pil = '0;
  logic irq_pending, trap_vld, post_err;
  logic [2:0] trap_code;
  logic [3:0] trap_lvl;
  logic [15:0] lvl_clr_mask;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  trap_irq_arbiter dut_i (.*);

  typedef struct packed {
    logic [6:0] pend; logic hp; logic en; logic tz; logic [2:0] tlv;
    logic [15:0] si; logic [3:0] pl; logic vld; logic [2:0] code;
    logic [3:0] lv; logic after; logic [3:0] rq;
  } vec_t;

  localparam vec_t TBL [17] = '{
    '{7'h0A,1'b1,1'b0,1'b0,3'd0,16'h0000,4'd0,1'b0,3'd0,4'd0,1'b1,4'd4},  // R4 gated
    '{7'h0A,1'b1,1'b1,1'b0,3'd0,16'h0000,4'd0,1'b1,3'd1,4'd0,1'b1,4'd4},  // R4 tick
    '{7'h0C,1'b1,1'b1,1'b0,3'd0,16'h0000,4'd0,1'b1,3'd2,4'd0,1'b1,4'd4},  // R4 vector
    '{7'h08,1'b1,1'b1,1'b0,3'd0,16'h0000,4'd0,1'b0,3'd0,4'd0,1'b1,4'd11}, // R11
    '{7'h03,1'b0,1'b0,1'b1,3'd0,16'h0000,4'd0,1'b1,3'd0,4'd0,1'b1,4'd5},  // R5
    '{7'h03,1'b0,1'b0,1'b1,3'd1,16'h0000,4'd0,1'b1,3'd1,4'd0,1'b1,4'd5},  // R5 tl!=0
    '{7'h0A,1'b0,1'b0,1'b0,3'd0,16'h0000,4'd0,1'b1,3'd1,4'd0,1'b1,4'd6},  // R6
    '{7'h78,1'b0,1'b1,1'b0,3'd0,16'h0100,4'd0,1'b1,3'd3,4'd0,1'b1,4'd7},  // R7
    '{7'h70,1'b0,1'b1,1'b0,3'd0,16'h0100,4'd0,1'b1,3'd4,4'd0,1'b1,4'd7},  // R7
    '{7'h60,1'b0,1'b1,1'b0,3'd0,16'h0100,4'd0,1'b1,3'd6,4'd8,1'b1,4'd9},  // R9
    '{7'h60,1'b0,1'b1,1'b0,3'd0,16'h0100,4'd8,1'b1,3'd5,4'd0,1'b1,4'd9},  // R9 pil
    '{7'h44,1'b0,1'b1,1'b0,3'd0,16'h0010,4'd0,1'b1,3'd2,4'd0,1'b1,4'd8},  // R8
    '{7'h44,1'b0,1'b1,1'b0,3'd0,16'h0100,4'd0,1'b1,3'd6,4'd8,1'b1,4'd8},  // R8
    '{7'h40,1'b0,1'b1,1'b0,3'd0,16'h0001,4'd0,1'b0,3'd0,4'd0,1'b1,4'd8},  // R8 bit0
    '{7'h40,1'b0,1'b1,1'b0,3'd0,16'h0101,4'd0,1'b1,3'd6,4'd8,1'b0,4'd10}, // R10
    '{7'h40,1'b0,1'b1,1'b0,3'd0,16'h0104,4'd0,1'b1,3'd6,4'd8,1'b1,4'd10}, // R10
    '{7'h20,1'b0,1'b0,1'b0,3'd0,16'h0000,4'd0,1'b0,3'd0,4'd0,1'b1,4'd11}  // R11
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic post(input logic [2:0] idx);
    @(negedge clk); post_vld = 1'b1; post_idx = idx;
    @(negedge clk); post_vld = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!irq_pending && !post_err, "R1", {irq_pending, post_err}, 0);
    take_req = 1'b1; hpriv = 1'b0; ie = 1'b1; #1;
    chk(!trap_vld, "R1", trap_vld, 0);
    take_req = 1'b0;

    for (int k = 0; k < 17; k++) begin
      do_reset();
      for (int s = 0; s < 7; s++) if (TBL[k].pend[s]) post(3'(s));
      @(negedge clk);
      hpriv = TBL[k].hp; ie = TBL[k].en; tlz_en = TBL[k].tz; tl = TBL[k].tlv;
      softint = TBL[k].si; pil = TBL[k].pl; take_req = 1'b1;
      #1;
      chk(trap_vld == TBL[k].vld, $sformatf("R%0d row%0d vld", TBL[k].rq, k), trap_vld, TBL[k].vld);
      if (TBL[k].vld) begin
        chk(trap_code == TBL[k].code, $sformatf("R%0d row%0d code", TBL[k].rq, k), trap_code, TBL[k].code);
        chk(trap_lvl == TBL[k].lv, $sformatf("R9 row%0d lvl", k), trap_lvl, TBL[k].lv);
        chk(lvl_clr_mask == ((TBL[k].lv != 0) ? (16'h1 << TBL[k].lv) : 16'h0),
            $sformatf("R9 row%0d mask", k), lvl_clr_mask, (TBL[k].lv != 0) ? (16'h1 << TBL[k].lv) : 0);
      end
      @(negedge clk); take_req = 1'b0; #1;
      chk(irq_pending == TBL[k].after, $sformatf("R%0d row%0d pending", TBL[k].rq, k), irq_pending, TBL[k].after);
    end

    // R2 idempotent post: twice posted, one take clears
    do_reset(); hpriv = 1'b0; ie = 1'b0; tlz_en = 1'b0; softint = '0; pil = '0;
    post(3'd1); post(3'd1); #1;
    chk(irq_pending, "R2", irq_pending, 1);
    @(negedge clk); take_req = 1'b1; #1;
    chk(trap_vld && trap_code == 3'd1, "R2", trap_code, 1);
    @(negedge clk); take_req = 1'b0; #1;
    chk(!irq_pending, "R2", irq_pending, 0);

    // R3 out-of-range post
    post(3'd7); #1;
    chk(post_err && !irq_pending, "R3", {post_err, irq_pending}, 2);
    repeat (3) @(negedge clk); #1;
    chk(post_err, "R3 sticky", post_err, 1);
    do_reset(); #1;
    chk(!post_err, "R1 err cleared", post_err, 0);

    // R12 post and take of same source in one cycle
    post(3'd1);
    @(negedge clk); post_vld = 1'b1; post_idx = 3'd1; take_req = 1'b1; #1;
    chk(trap_vld && trap_code == 3'd1, "R12 take", trap_code, 1);
    @(negedge clk); post_vld = 1'b0; take_req = 1'b0; #1;
    chk(irq_pending, "R12 flag kept", irq_pending, 1);

    finish_run();
  end
endmodule